// File: doc/BRIEF.md
# Scaling Dual-Channel Sample FIFO

This block is the sample store at the front of an asynchronous sample-rate converter. Each time an input sample strobe arrives, it takes one left and one right sample, multiplies both by a single gain, rounds the products back to the sample width and writes them into two circular memories, one per channel. The convolution engine that follows reads both memories at any address through a registered read port.

The gain has two parts. The first is a rate-ratio attenuation. When the converter decimates, the caller supplies the output/input rate ratio as an unsigned fraction. Scaling each sample by that ratio before storage keeps the longer convolution from saturating. Ratios of unity or more (interpolation) leave the samples unscaled. The second part is a soft-mute level. It moves by a fixed step on every accepted sample, down toward zero while mute is requested and back up to full scale when the request is released.

The write address is an input-sample counter plus a fixed guard offset, modulo the memory depth. The counter's current write address is exported so the rate-tracking logic can place its read window a safe distance behind it.

Top module: `scaled_dual_fifo`

## Requirements
- R1: After reset the write address `wr_addr` is GUARD (16), and the mute level is full scale, so the first sample is stored unscaled when the ratio is unity.
- R2: Each accepted sample (`in_valid`=1 at a clock edge) is written at `wr_addr`, and `wr_addr` then advances by one. `wr_addr` equals the accepted-sample count plus 16, modulo DEPTH (512), so sample number k after reset lands at address (k+16) mod 512.
- R3: `rd_left` and `rd_right` show the stored words at `rd_addr` one clock after the address is presented. The two channels are stored and read independently.
- R4: `ratio_gain` is an unsigned fraction in which 32768 (2^(GAIN_W-1)) means 1.0. At full mute level a sample s is stored as floor((s*ratio + 16384) / 32768).
- R5: A `ratio_gain` of 32768 or more is treated as exactly 1.0, so the sample is stored unchanged.
- R6: While `mute_req`=1, each accepted sample lowers the mute level by MUTE_STEP, down to a floor of 0. The sample accepted in that cycle is scaled by the level that held before the step.
- R7: While `mute_req`=0, each accepted sample raises the mute level by MUTE_STEP, up to a ceiling of full scale (32768). The sample uses the level that held before the step.
- R8: The combined gain is g = floor((level*ratio + 16384) / 32768), where the ratio is clamped as in R5, and the sample is stored as floor((s*g + 16384) / 32768).
- R9: Products are rounded half toward positive infinity and limited to the signed DATA_W range; for example 3*0.5 is stored as 2 and -3*0.5 as -1.
- R10: In cycles with `in_valid`=0, `in_left`, `in_right`, `ratio_gain` and `mute_req` are ignored. Neither `wr_addr` nor the mute level changes, and no memory word is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input sample strobe, one accepted sample pair per high cycle |
| in_left | input | DATA_W | Left input sample, signed |
| in_right | input | DATA_W | Right input sample, signed |
| ratio_gain | input | GAIN_W | Output/input rate ratio, unsigned, 2^(GAIN_W-1) = 1.0 |
| mute_req | input | 1 | Soft-mute request, 1 ramps the level down, 0 ramps it up |
| wr_addr | output | log2(DEPTH) | Address the next accepted sample is written to |
| rd_addr | input | log2(DEPTH) | Read address from the convolution engine |
| rd_left | output | DATA_W | Left word at the previous cycle's `rd_addr`, signed |
| rd_right | output | DATA_W | Right word at the previous cycle's `rd_addr`, signed |

## Verification
The bench builds the block with DATA_W=16, GAIN_W=16, DEPTH=512 and GUARD=16, which are the sizes the converter uses. It raises MUTE_STEP to 8192, so a full ramp takes four samples. At that step the floor, the ceiling and a half-muted level multiplied by a fractional ratio can all be reached and checked word by word. With a 512-word memory, about five hundred accepted samples carry the write address across the wrap from 511 to 0, so the modulo addressing is covered in one short run.

// File: rtl/sfifo_pkg.sv
// Package: shared types and constants for the scaling dual-channel FIFO.
// Assumes nothing beyond being compiled before the modules that import it.
package sfifo_pkg;

    // Number of audio channels stored side by side
    localparam int NUM_CH = 2;

    // Channel index names
    typedef enum logic {
        CH_LEFT  = 1'b0,
        CH_RIGHT = 1'b1
    } chan_e;

endpackage

// File: rtl/sfifo_gain_ctrl.sv
// Gain controller: keeps the soft-mute level and combines it with the
// rate-ratio attenuation into one unsigned gain (2^(GAIN_W-1) = 1.0).
// Assumes: the level moves only on accepted samples, and the gain it outputs
// is the one for the sample accepted in the current cycle (pre-step level).
module sfifo_gain_ctrl #(
    parameter int GAIN_W    = 16,
    parameter int MUTE_STEP = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              mute_req,
    input  logic [GAIN_W-1:0] ratio_gain,
    output logic [GAIN_W-1:0] gain
);
    localparam int              FRAC = GAIN_W - 1;
    localparam logic [GAIN_W-1:0] FULL = GAIN_W'(1) << FRAC;
    localparam logic [GAIN_W-1:0] STEP = GAIN_W'(MUTE_STEP);
    localparam logic [2*GAIN_W-1:0] HALF = (2*GAIN_W)'(1) << (FRAC - 1);

    logic [GAIN_W-1:0]   level_q;
    logic [GAIN_W-1:0]   level_d;
    logic [GAIN_W-1:0]   ratio_c;
    logic [2*GAIN_W-1:0] prod;

    // Next mute level: one step toward zero or full scale, clamped
    always_comb begin
        if (mute_req) begin
            level_d = (level_q > STEP) ? level_q - STEP : '0;
        end else begin
            level_d = ((FULL - level_q) > STEP) ? level_q + STEP : FULL;
        end
    end

    // Mute level register, moves only on accepted samples
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= FULL;
        end else if (in_valid) begin
            level_q <= level_d;
        end
    end

    // Clamp the ratio to unity and merge it with the mute level
    always_comb begin
        ratio_c = (ratio_gain > FULL) ? FULL : ratio_gain;
        prod    = ((2*GAIN_W)'(level_q) * (2*GAIN_W)'(ratio_c)) + HALF;
        gain    = GAIN_W'(prod >> FRAC);
    end

    // R7: the level never exceeds full scale
    assert_level_ceiling_R7: assert property (@(posedge clk) disable iff (!rst_n)
        level_q <= FULL);

    // R6: a mute request lowers the level by one step per accepted sample
    assert_ramp_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mute_req && level_q >= STEP) |=> (level_q == $past(level_q) - STEP));

    // R6: the floor is zero
    assert_ramp_floor_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mute_req && level_q < STEP) |=> (level_q == '0));

    // R7: released mute raises the level by one step per accepted sample
    assert_ramp_up_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !mute_req && level_q <= FULL - STEP) |=> (level_q == $past(level_q) + STEP));

    // R10: no accepted sample, no level change
    assert_level_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(level_q));

    // R8: combined gain never exceeds unity
    assert_gain_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        gain <= FULL);

endmodule

// File: rtl/sfifo_scaler.sv
// Sample scaler: multiplies a signed sample by an unsigned gain
// (2^(GAIN_W-1) = 1.0), rounds half toward +inf and saturates to DATA_W.
// Assumes: purely combinational, used in the write cycle.
module sfifo_scaler #(
    parameter int DATA_W = 16,
    parameter int GAIN_W = 16
) (
    input  logic signed [DATA_W-1:0] sample,
    input  logic        [GAIN_W-1:0] gain,
    output logic signed [DATA_W-1:0] scaled
);
    localparam int FRAC = GAIN_W - 1;
    localparam int PW   = DATA_W + GAIN_W + 1;
    localparam logic signed [PW-1:0] HALF = PW'(1) << (FRAC - 1);
    localparam logic signed [PW-1:0] MAXV = PW'((1 << (DATA_W - 1)) - 1);
    localparam logic signed [PW-1:0] MINV = -(PW'(1) << (DATA_W - 1));

    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] rounded;

    // Full-width product, rounding offset and arithmetic shift back
    always_comb begin
        prod    = {{(GAIN_W + 1){sample[DATA_W-1]}}, sample} * {{(DATA_W + 1){1'b0}}, gain};
        rounded = (prod + HALF) >>> FRAC;
    end

    // Saturate the rounded value to the stored sample width
    always_comb begin
        if (rounded > MAXV) begin
            scaled = MAXV[DATA_W-1:0];
        end else if (rounded < MINV) begin
            scaled = MINV[DATA_W-1:0];
        end else begin
            scaled = rounded[DATA_W-1:0];
        end
    end

endmodule

// File: rtl/sfifo_chan_ram.sv
// Channel memory: DEPTH words, one synchronous write port and one
// registered read port (data one clock after the address, read-first).
// Assumes: contents are not reset; only written words are meaningful.
module sfifo_chan_ram #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 512,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic        [ADDR_W-1:0] waddr,
    input  logic signed [DATA_W-1:0] wdata,
    input  logic        [ADDR_W-1:0] raddr,
    output logic signed [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Store the scaled sample on an accepted write
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Registered read of the requested word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else begin
            rdata <= mem[raddr];
        end
    end

endmodule

// File: rtl/scaled_dual_fifo.sv
// Top: scaling dual-channel sample FIFO. Counts accepted input samples,
// forms the write address as count + GUARD (mod DEPTH), scales both
// channels by the shared gain and stores them; serves random reads.
// Assumes: DEPTH is a power of two, GUARD < DEPTH, MUTE_STEP <= 2^(GAIN_W-1).
module scaled_dual_fifo
    import sfifo_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int GAIN_W    = 16,
    parameter int DEPTH     = 512,
    parameter int GUARD     = 16,
    parameter int MUTE_STEP = 64,
    localparam int ADDR_W   = $clog2(DEPTH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_left,
    input  logic signed [DATA_W-1:0] in_right,
    input  logic        [GAIN_W-1:0] ratio_gain,
    input  logic                     mute_req,
    output logic        [ADDR_W-1:0] wr_addr,
    input  logic        [ADDR_W-1:0] rd_addr,
    output logic signed [DATA_W-1:0] rd_left,
    output logic signed [DATA_W-1:0] rd_right
);
    logic [ADDR_W-1:0]        count_q;
    logic [GAIN_W-1:0]        gain;
    logic signed [DATA_W-1:0] ch_in     [NUM_CH];
    logic signed [DATA_W-1:0] ch_scaled [NUM_CH];
    logic signed [DATA_W-1:0] ch_rd     [NUM_CH];

    // Input sample counter, wraps at DEPTH
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (in_valid) begin
            count_q <= count_q + 1'b1;
        end
    end

    // Write address: counter plus guard offset, modulo DEPTH
    assign wr_addr = count_q + ADDR_W'(GUARD);

    // Shared mute and ratio gain
    sfifo_gain_ctrl #(
        .GAIN_W    (GAIN_W),
        .MUTE_STEP (MUTE_STEP)
    ) u_gain (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .mute_req   (mute_req),
        .ratio_gain (ratio_gain),
        .gain       (gain)
    );

    // Route channels in and out of the per-channel arrays
    assign ch_in[CH_LEFT]  = in_left;
    assign ch_in[CH_RIGHT] = in_right;
    assign rd_left  = ch_rd[CH_LEFT];
    assign rd_right = ch_rd[CH_RIGHT];

    // One scaler and one memory per channel
    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        sfifo_scaler #(
            .DATA_W (DATA_W),
            .GAIN_W (GAIN_W)
        ) u_scale (
            .sample (ch_in[c]),
            .gain   (gain),
            .scaled (ch_scaled[c])
        );

        sfifo_chan_ram #(
            .DATA_W (DATA_W),
            .DEPTH  (DEPTH)
        ) u_ram (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (in_valid),
            .waddr (wr_addr),
            .wdata (ch_scaled[c]),
            .raddr (rd_addr),
            .rdata (ch_rd[c])
        );
    end

    // R2: every accepted sample advances the write position by one
    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (count_q == $past(count_q) + 1'b1));

    // R10: the write position holds when no sample is accepted
    assert_count_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(count_q));

    // R4: with a gain of at most unity a non-negative sample never grows
    assert_no_growth_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_left[DATA_W-1]) |->
            (!ch_scaled[CH_LEFT][DATA_W-1] && ch_scaled[CH_LEFT] <= in_left));

    // R9: a negative sample stays non-positive and no smaller than itself
    assert_neg_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_right[DATA_W-1]) |->
            (ch_scaled[CH_RIGHT] <= 0 && ch_scaled[CH_RIGHT] >= in_right));

endmodule

// File: tb/tb_scaled_dual_fifo.sv
module tb_scaled_dual_fifo;
    localparam int DW    = 16;
    localparam int GW    = 16;
    localparam int DEPTH = 512;
    localparam int GUARD = 16;
    localparam int STEP  = 8192;
    localparam int AW    = $clog2(DEPTH);

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 in_valid = 1'b0;
    logic signed [DW-1:0] in_left = '0;
    logic signed [DW-1:0] in_right = '0;
    logic        [GW-1:0] ratio_gain = GW'(32768);
    logic                 mute_req = 1'b0;
    logic        [AW-1:0] wr_addr;
    logic        [AW-1:0] rd_addr = '0;
    logic signed [DW-1:0] rd_left;
    logic signed [DW-1:0] rd_right;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    scaled_dual_fifo #(
        .DATA_W (DW), .GAIN_W (GW), .DEPTH (DEPTH), .GUARD (GUARD), .MUTE_STEP (STEP)
    ) dut (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_left (in_left),
        .in_right (in_right), .ratio_gain (ratio_gain), .mute_req (mute_req),
        .wr_addr (wr_addr), .rd_addr (rd_addr), .rd_left (rd_left), .rd_right (rd_right)
    );

    // Vectors: left in, right in, ratio, expected left, expected right
    localparam int TV [8][5] = '{
        '{  1000, -1000, 32768,  1000, -1000},   // R5 unity
        '{ 32767,-32768, 40000, 32767,-32768},   // R5 ratio above unity clamps
        '{  1000, -1000, 16384,   500,  -500},   // R4 half
        '{     3,    -3, 16384,     2,    -1},   // R9 rounding half up
        '{ 12000, -7000,  8192,  3000, -1750},   // R4 quarter
        '{   100,     1,     0,     0,     0},   // R4 zero ratio
        '{ 20000,-20000,  4228,  2581, -2581},   // R4 deepest decimation
        '{     7,    -7, 32767,     7,    -7}    // R9 just below unity
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic push(input int l, input int r, input int ratio, input bit mute);
        @(negedge clk);
        in_left    = DW'(l);
        in_right   = DW'(r);
        ratio_gain = GW'(ratio);
        mute_req   = mute;
        in_valid   = 1'b1;
        @(negedge clk);
        in_valid   = 1'b0;
    endtask

    task automatic readback(input int addr, input int el, input int er, input string req);
        @(negedge clk);
        rd_addr = AW'(addr);
        @(negedge clk);
        check(req, int'(rd_left), el);
        check(req, int'(rd_right), er);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        #(4 * 100000);
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int exp_l [6];
        do_reset();
        // R1: reset write address
        check("R1 wr_addr after reset", int'(wr_addr), GUARD);

        // Table walk: write all vectors, then read them back (R3)
        for (int i = 0; i < 8; i++) begin
            push(TV[i][0], TV[i][1], TV[i][2], 1'b0);
        end
        check("R2 wr_addr after 8 samples", int'(wr_addr), GUARD + 8);
        for (int i = 0; i < 8; i++) begin
            readback(GUARD + i, TV[i][3], TV[i][4], "R3/R4/R5/R9 table");
        end

        // R6: ramp down, levels used 32768,24576,16384,8192,0,0
        exp_l = '{1000, 750, 500, 250, 0, 0};
        for (int i = 0; i < 6; i++) push(1000, -1000, 32768, 1'b1);
        for (int i = 0; i < 6; i++) readback(24 + i, exp_l[i], -exp_l[i], "R6 mute ramp down");

        // R7: ramp up, levels used 0,8192,16384,24576,32768,32768
        exp_l = '{0, 250, 500, 750, 1000, 1000};
        for (int i = 0; i < 6; i++) push(1000, -1000, 32768, 1'b0);
        for (int i = 0; i < 6; i++) readback(30 + i, exp_l[i], -exp_l[i], "R7 unmute ramp up");

        // R8: level 16384 combined with ratio 16384 gives gain 8192
        push(1000, -1000, 32768, 1'b1);
        push(1000, -1000, 32768, 1'b1);
        push(1000, -1000, 16384, 1'b1);
        readback(38, 250, -250, "R8 combined gain");
        push(1000, -1000, 32768, 1'b0);
        push(1000, -1000, 32768, 1'b0);
        push(1000, -1000, 32768, 1'b0);
        readback(39, 250, -250, "R7 recover");
        readback(41, 750, -750, "R7 recover");

        // R10: idle cycles with mute requested and data wiggling change nothing
        @(negedge clk);
        mute_req = 1'b1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            in_left  = DW'(i * 111);
            in_right = DW'(-i * 77);
        end
        check("R10 wr_addr held while idle", int'(wr_addr), 42);
        readback(42, 0, 0, "R10 no write while idle");
        push(1000, -1000, 32768, 1'b0);
        readback(42, 1000, -1000, "R10 level held while idle");

        // R2: wrap of the write address; sample k lands at (k+16) mod 512
        for (int k = 27; k < 500; k++) push(k, -k, 32768, 1'b0);
        check("R2 wr_addr after wrap", int'(wr_addr), (500 + GUARD) % DEPTH);
        readback(511, 495, -495, "R2 last address before wrap");
        readback(0, 496, -496, "R2 first address after wrap");
        readback(3, 499, -499, "R2 after wrap");

        // R1: reset mid-ramp restores full level and address
        push(1000, -1000, 32768, 1'b1);
        push(1000, -1000, 32768, 1'b1);
        do_reset();
        check("R1 wr_addr after second reset", int'(wr_addr), GUARD);
        push(1000, -1000, 32768, 1'b0);
        readback(GUARD, 1000, -1000, "R1 full level after reset");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule